// File: doc/BRIEF.md
# SPI Status Flag Interrupt Controller

This block keeps the four status flags of an SPI peripheral (transmit buffer empty, receive buffer full, receive overflow and mode fault) and turns them into two CPU interrupt requests. The shift engine reports events through one-cycle set pulses. The register interface reports bus accesses through one-cycle strobes: a status register read, a receive data register read and a transmit data register write. The SPI enable, the three interrupt enables and the mode-fault enable arrive as static control levels.

The receive-side flags are not cleared by writing ones to them. Software must first read the status register while the flag is set, and then read the receive data register. A new reception that arrives between those two reads cancels the pending clear. The transmit-empty flag clears on any write to the transmit data. The transmit request is gated by the SPI enable. The receive/error request is not gated by the SPI enable.

Top module: `spi_flag_irq`

## Requirements
- R1: After reset, `flag_txe` is 1, `flag_rxf`, `flag_ovr` and `flag_mdf` are 0, and both `irq_tx` and `irq_rxerr` are 0.
- R2: A `set_txe` pulse makes `flag_txe` 1 on the next cycle. A `wr_txdata` strobe makes it 0 on the next cycle, and no earlier status read is needed.
- R3: `flag_rxf` clears only when `rd_rxdata` occurs in a cycle after a `rd_status` that was taken while `flag_rxf` was 1. A `rd_rxdata` without that earlier read, or in the same cycle as the status read, leaves the flag set.
- R4: A `set_rxf` pulse that arrives between the arming status read and the data read cancels the pending clear, so the following `rd_rxdata` leaves `flag_rxf` set.
- R5: `flag_ovr` is set by `set_ovr`. It clears through the same status-read-then-data-read sequence as R3, with its own arming, and a new `set_ovr` cancels that arming.
- R6: When a set pulse and a clear condition for the same flag occur in one cycle, the flag is 1 on the next cycle.
- R7: While `en_mdf` is 1, `set_mdf` sets `flag_mdf`. While `en_mdf` is 0, `flag_mdf` is 0 on the next cycle and `set_mdf` has no effect.
- R8: `irq_tx` is 1 exactly when `flag_txe`, `ie_tx` and `en_spi` are all 1.
- R9: The receive term of `irq_rxerr` is `flag_rxf` AND `ie_rx`, whatever the value of `en_spi`.
- R10: `irq_rxerr` is the OR of the receive term and `ie_err` AND (`flag_ovr` OR `flag_mdf`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_txe | input | 1 | Shift engine: transmit buffer emptied |
| set_rxf | input | 1 | Shift engine: byte received |
| set_ovr | input | 1 | Shift engine: reception overflowed |
| set_mdf | input | 1 | Shift engine: mode fault detected |
| rd_status | input | 1 | Bus strobe: status register read |
| rd_rxdata | input | 1 | Bus strobe: receive data register read |
| wr_txdata | input | 1 | Bus strobe: transmit data register write |
| en_spi | input | 1 | SPI enable |
| ie_tx | input | 1 | Transmit interrupt enable |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_err | input | 1 | Error interrupt enable |
| en_mdf | input | 1 | Mode-fault enable |
| flag_txe | output | 1 | Transmit-empty flag |
| flag_rxf | output | 1 | Receive-full flag |
| flag_ovr | output | 1 | Overflow flag |
| flag_mdf | output | 1 | Mode-fault flag |
| irq_tx | output | 1 | Transmitter interrupt request |
| irq_rxerr | output | 1 | Receiver/error interrupt request |

## Verification
Directed sequences first walk through each clear path. A data read with no status read before it shows that the sequence is really required. A status read and a data read in the same cycle show that the status read must come earlier. A reception between the two reads shows the disarm, and a set that coincides with a clear shows that the set wins. The enable levels are toggled, including `en_spi` low with `ie_rx` high, to separate the gated transmit request from the ungated receive request. A long run of sparse random pulses and strobes then compares every flag and both requests against a behavioural model on every clock.

// File: rtl/spi_flag_irq.sv
module spi_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_txe,
  input  logic set_rxf,
  input  logic set_ovr,
  input  logic set_mdf,
  input  logic rd_status,
  input  logic rd_rxdata,
  input  logic wr_txdata,
  input  logic en_spi,
  input  logic ie_tx,
  input  logic ie_rx,
  input  logic ie_err,
  input  logic en_mdf,
  output logic flag_txe,
  output logic flag_rxf,
  output logic flag_ovr,
  output logic flag_mdf,
  output logic irq_tx,
  output logic irq_rxerr
);

  logic arm_rxf, arm_ovr;
  logic clr_rxf, clr_ovr;

  assign clr_rxf = rd_rxdata & arm_rxf & flag_rxf;
  assign clr_ovr = rd_rxdata & arm_ovr & flag_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_txe <= 1'b1;
      flag_rxf <= 1'b0;
      flag_ovr <= 1'b0;
      flag_mdf <= 1'b0;
      arm_rxf  <= 1'b0;
      arm_ovr  <= 1'b0;
    end else begin
      flag_txe <= set_txe | (flag_txe & ~wr_txdata);
      flag_rxf <= set_rxf | (flag_rxf & ~clr_rxf);
      flag_ovr <= set_ovr | (flag_ovr & ~clr_ovr);
      flag_mdf <= en_mdf & (set_mdf | flag_mdf);

      if (set_rxf || clr_rxf)        arm_rxf <= 1'b0;
      else if (rd_status && flag_rxf) arm_rxf <= 1'b1;

      if (set_ovr || clr_ovr)        arm_ovr <= 1'b0;
      else if (rd_status && flag_ovr) arm_ovr <= 1'b1;
    end
  end

  assign irq_tx    = flag_txe & ie_tx & en_spi;
  assign irq_rxerr = (flag_rxf & ie_rx) | (ie_err & (flag_ovr | flag_mdf));

  assert_txe_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txdata && !set_txe) |=> !flag_txe);

  assert_rxf_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rxf && !arm_rxf) |=> flag_rxf);

  assert_rxf_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_rxf |=> !arm_rxf);

  assert_ovr_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovr && !arm_ovr) |=> flag_ovr);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_rxf || set_ovr) |=> (flag_rxf || !$past(set_rxf)) && (flag_ovr || !$past(set_ovr)));

  assert_mdf_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_mdf |=> !flag_mdf);

  assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> en_spi);

  assert_rx_ungated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rxf && ie_rx) |-> irq_rxerr);

  assert_err_term_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rxerr && !ie_rx) |-> (ie_err && (flag_ovr || flag_mdf)));

endmodule

// File: tb/spi_flag_irq_tb.sv
module spi_flag_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic set_txe = 0, set_rxf = 0, set_ovr = 0, set_mdf = 0;
  logic rd_status = 0, rd_rxdata = 0, wr_txdata = 0;
  logic en_spi = 0, ie_tx = 0, ie_rx = 0, ie_err = 0, en_mdf = 0;
  logic flag_txe, flag_rxf, flag_ovr, flag_mdf, irq_tx, irq_rxerr;

  int n_chk = 0, n_bad = 0;
  bit m_txe = 1, m_rxf = 0, m_ovr = 0, m_mdf = 0, m_arx = 0, m_aov = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_irq u_dut (
    .clk(clk), .rst_n(rst_n),
    .set_txe(set_txe), .set_rxf(set_rxf), .set_ovr(set_ovr), .set_mdf(set_mdf),
    .rd_status(rd_status), .rd_rxdata(rd_rxdata), .wr_txdata(wr_txdata),
    .en_spi(en_spi), .ie_tx(ie_tx), .ie_rx(ie_rx), .ie_err(ie_err), .en_mdf(en_mdf),
    .flag_txe(flag_txe), .flag_rxf(flag_rxf), .flag_ovr(flag_ovr), .flag_mdf(flag_mdf),
    .irq_tx(irq_tx), .irq_rxerr(irq_rxerr)
  );

  task automatic chk(input logic act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit etx, erx;
    etx = m_txe && ie_tx && en_spi;
    erx = (m_rxf && ie_rx) || (ie_err && (m_ovr || m_mdf));
    chk(flag_txe, m_txe, "R2 flag_txe");
    chk(flag_rxf, m_rxf, "R3 flag_rxf");
    chk(flag_ovr, m_ovr, "R5 flag_ovr");
    chk(flag_mdf, m_mdf, "R7 flag_mdf");
    chk(irq_tx, etx, "R8 irq_tx");
    chk(irq_rxerr, erx, "R9/R10 irq_rxerr");
  endtask

  task automatic model_step();
    bit crx, cov;
    crx = rd_rxdata && m_arx && m_rxf;
    cov = rd_rxdata && m_aov && m_ovr;
    if (set_rxf || crx) m_arx = 0; else if (rd_status && m_rxf) m_arx = 1;
    if (set_ovr || cov) m_aov = 0; else if (rd_status && m_ovr) m_aov = 1;
    m_txe = set_txe || (m_txe && !wr_txdata);
    m_rxf = set_rxf || (m_rxf && !crx);
    m_ovr = set_ovr || (m_ovr && !cov);
    m_mdf = en_mdf && (m_mdf || set_mdf);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    {set_txe, set_rxf, set_ovr, set_mdf, rd_status, rd_rxdata, wr_txdata} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(flag_txe, 1, "R1 flag_txe"); chk(flag_rxf, 0, "R1 flag_rxf");
    chk(flag_ovr, 0, "R1 flag_ovr"); chk(flag_mdf, 0, "R1 flag_mdf");
    chk(irq_tx, 0, "R1 irq_tx");     chk(irq_rxerr, 0, "R1 irq_rxerr");
    rst_n = 1;
    en_spi = 1; ie_tx = 1; ie_rx = 1; ie_err = 1; en_mdf = 1;
    cyc();
    // R2: write clears without status read; set restores; R8 gate
    wr_txdata = 1; cyc();
    set_txe = 1; cyc();
    en_spi = 0; cyc();
    en_spi = 1;
    // R6: set and clear together
    set_txe = 1; wr_txdata = 1; cyc();
    // R3: data read without arm keeps flag; same-cycle reads keep flag
    set_rxf = 1; cyc();
    en_spi = 0; cyc();             // R9: rx request ignores en_spi
    en_spi = 1;
    rd_rxdata = 1; cyc();
    rd_status = 1; rd_rxdata = 1; cyc();
    rd_rxdata = 1; cyc();          // armed by previous status read -> clears
    // R3 proper: status then data
    set_rxf = 1; cyc();
    rd_status = 1; cyc();
    rd_rxdata = 1; cyc();
    // R4: reception in between disarms
    set_rxf = 1; cyc();
    rd_status = 1; cyc();
    set_rxf = 1; cyc();
    rd_rxdata = 1; cyc();
    rd_status = 1; cyc();
    rd_rxdata = 1; cyc();
    // R5: overflow sequence and disarm
    set_ovr = 1; cyc();
    rd_rxdata = 1; cyc();
    rd_status = 1; cyc();
    set_ovr = 1; cyc();
    rd_rxdata = 1; cyc();
    rd_status = 1; cyc();
    rd_rxdata = 1; cyc();
    // R6: set coincides with armed clear
    set_rxf = 1; cyc();
    rd_status = 1; cyc();
    rd_rxdata = 1; set_rxf = 1; cyc();
    // R7: mode fault held while disabled; R10 error term
    en_mdf = 0; set_mdf = 1; cyc();
    en_mdf = 1; set_mdf = 1; cyc();
    ie_rx = 0; cyc();
    ie_err = 0; cyc();
    en_mdf = 0; ie_err = 1; cyc();
    // random phase
    for (int i = 0; i < 6000; i++) begin
      set_txe   = ($urandom % 8) == 0;
      set_rxf   = ($urandom % 10) == 0;
      set_ovr   = ($urandom % 16) == 0;
      set_mdf   = ($urandom % 16) == 0;
      rd_status = ($urandom % 4) == 0;
      rd_rxdata = ($urandom % 4) == 0;
      wr_txdata = ($urandom % 6) == 0;
      if (($urandom % 32) == 0) begin
        en_spi = $urandom; ie_tx = $urandom; ie_rx = $urandom;
        ie_err = $urandom; en_mdf = ($urandom % 4) != 0;
      end
      cyc();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule